// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an asynchronous static RAM of 32,768 bytes. It does one access at a time: the host hands over a read or a write through a valid/ready request port, and the controller runs the memory's active-low chip select, output enable and write strobe through a fixed series of phases. Each phase lasts a whole number of clocks. The phase lengths come from nanosecond minimums, given as picosecond parameters, which are divided by the clock-period parameter and rounded up. The shared data bus is split at this boundary into a drive value, a drive enable and a sampled input, and a pad cell outside the block joins them.

The request port takes a request only when `req_valid` and `req_ready` are both high at a rising edge. `req_ready` is high only while the controller is idle. A host that holds `req_valid` during an access is back-pressured: nothing is taken until the current access has finished. Completion is a plain one-clock `done` pulse. For a read, `rd_data` is valid with that pulse and keeps its value until the next read completes. With no request waiting, the memory is left deselected.

Top module: `async_sram_ctl`

## Requirements
- R1: Out of reset, chip select, output enable and write strobe are high (deasserted), the data drive enable is low, `req_ready` is 1 and `done` is 0.
- R2: `req_ready` is 1 only in idle, and a request is taken at a rising edge where `req_valid` and `req_ready` are both 1. From the next cycle on, `sram_addr` shows the request address and holds it for as long as chip select stays low.
- R3: A read keeps chip select and output enable low and the write strobe high for RD cycles. RD is the largest of ceil(t/period) over the read-cycle time (12 ns), address access (12 ns), select access (12 ns) and output-enable access (6 ns), with a minimum of 1.
- R4: `sram_dq_i` is sampled at the clock edge that ends the last read cycle. In the next cycle `done` is 1 and `rd_data` holds that byte, and `rd_data` keeps it until the next read completes.
- R5: A write pulse keeps chip select and the write strobe low and output enable high, with the drive enable high and `sram_dq_o` equal to the request data. It lasts WP cycles, the largest of ceil(t/period) over write pulse (10 ns), select-to-end (10 ns), address-to-end (10 ns) and data setup (6 ns), with a minimum of 1.
- R6: After the write pulse, the write strobe is high, chip select stays low, the drive enable is low and the address is held. This recovery lasts max(1, ceil(write-cycle time/period) − WP) cycles, where the write-cycle time defaults to 12 ns. `done` follows in the next cycle.
- R7: When the previous completed access was a read, a write starts with a turnaround of max(1, ceil(6 ns release/period)) cycles. During the turnaround chip select is low, output enable and the write strobe are high, and the drive enable is low.
- R8: The drive enable is high only while the write strobe is low and output enable is high, never while the memory may be driving the bus.
- R9: In every idle cycle chip select is high, and `done` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request accepted at this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Byte from the last completed read |
| sram_addr | output | 15 | Memory address lines |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_dq_o | output | 8 | Byte driven onto the shared bus |
| sram_dq_oe | output | 1 | Bus drive enable, 1 = controller drives |
| sram_dq_i | input | 8 | Byte sampled from the shared bus |

## Verification
The bench builds the controller with a 4 ns clock period and the write-cycle minimum raised to 20 ns. Every other timing keeps its default. With these values a read lasts 3 cycles, a write pulse 3 cycles, the write recovery 2 cycles and the read-to-write turnaround 2 cycles. Each phase therefore spans more than one clock, and the counter reload, the recovery stretching and the turnaround length are all exercised beyond their one-cycle minimums. The tests include accesses at address 0 and at the top address 0x7FFF, a read of data that was never written, and every ordering of read and write pairs.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_READ  = 3'd1,
    PH_TURN  = 3'd2,
    PH_WPULS = 3'd3,
    PH_WREC  = 3'd4
  } phase_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } pin_t;

  function automatic int unsigned ps_to_clk(input int unsigned ps, input int unsigned period);
    if (ps == 0) return 0;
    return (ps + period - 1) / period;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic pin_t phase_pins(input phase_e ph);
    pin_t p;
    case (ph)
      PH_READ:  p = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, dq_oe: 1'b0};
      PH_TURN:  p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
      PH_WPULS: p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, dq_oe: 1'b1};
      PH_WREC:  p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
      default:  p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count_q <= '0;
    else if (load)           count_q <= load_val;
    else if (count_q != '0)  count_q <= count_q - 1'b1;
  end

  assign last = (count_q == '0);

  assert_timer_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count_q == $past(load_val)));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned RD_CYC = 2,
  parameter int unsigned WP_CYC = 1,
  parameter int unsigned RC_CYC = 1,
  parameter int unsigned TA_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             timer_last,
  output logic             req_ready,
  output logic             req_fire,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output phase_e           phase_d,
  output logic             capture,
  output logic             finish
);
  phase_e phase_q;
  logic   last_rd_q;

  assign req_ready = (phase_q == PH_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign capture   = (phase_q == PH_READ) && timer_last;

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    finish   = 1'b0;
    case (phase_q)
      PH_IDLE: if (req_fire) begin
        tmr_load = 1'b1;
        if (!req_write) begin
          phase_d = PH_READ;
          tmr_val = CNT_W'(RD_CYC - 1);
        end else if (last_rd_q) begin
          phase_d = PH_TURN;
          tmr_val = CNT_W'(TA_CYC - 1);
        end else begin
          phase_d = PH_WPULS;
          tmr_val = CNT_W'(WP_CYC - 1);
        end
      end
      PH_READ: if (timer_last) begin
        phase_d = PH_IDLE;
        finish  = 1'b1;
      end
      PH_TURN: if (timer_last) begin
        phase_d  = PH_WPULS;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WP_CYC - 1);
      end
      PH_WPULS: if (timer_last) begin
        phase_d  = PH_WREC;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(RC_CYC - 1);
      end
      PH_WREC: if (timer_last) begin
        phase_d = PH_IDLE;
        finish  = 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      last_rd_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (finish) last_rd_q <= (phase_q == PH_READ);
    end
  end

  assert_turn_then_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TURN) |=> (phase_q == PH_TURN || phase_q == PH_WPULS));

endmodule

// File: rtl/sram_pin_stage.sv
module sram_pin_stage
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_d,
  input  logic              req_fire,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe
);
  pin_t pins_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= phase_pins(PH_IDLE);
      addr_q <= '0;
      wdat_q <= '0;
    end else begin
      pins_q <= phase_pins(phase_d);
      if (req_fire) begin
        addr_q <= req_addr;
        wdat_q <= req_wdata;
      end
    end
  end

  assign sram_ce_n  = pins_q.ce_n;
  assign sram_oe_n  = pins_q.oe_n;
  assign sram_we_n  = pins_q.we_n;
  assign sram_dq_oe = pins_q.dq_oe;
  assign sram_addr  = addr_q;
  assign sram_dq_o  = wdat_q;

  assert_drive_in_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (!sram_we_n && sram_oe_n && !sram_ce_n));

  assert_read_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (sram_we_n && !sram_ce_n));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

  assert_recover_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> !sram_ce_n);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              finish,
  input  logic [DATA_W-1:0] sram_dq_i,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= finish;
      if (capture) rd_data <= sram_dq_i;
    end
  end

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned T_RC_PS       = 12000,
  parameter int unsigned T_AA_PS       = 12000,
  parameter int unsigned T_ACE_PS      = 12000,
  parameter int unsigned T_OE_PS       = 6000,
  parameter int unsigned T_WP_PS       = 10000,
  parameter int unsigned T_CW_PS       = 10000,
  parameter int unsigned T_AW_PS       = 10000,
  parameter int unsigned T_DW_PS       = 6000,
  parameter int unsigned T_WC_PS       = 12000,
  parameter int unsigned T_HZ_PS       = 6000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam int unsigned RD_CYC = umax(1, umax(umax(ps_to_clk(T_RC_PS, CLK_PERIOD_PS),
                                                     ps_to_clk(T_AA_PS, CLK_PERIOD_PS)),
                                                umax(ps_to_clk(T_ACE_PS, CLK_PERIOD_PS),
                                                     ps_to_clk(T_OE_PS, CLK_PERIOD_PS))));
  localparam int unsigned WP_CYC = umax(1, umax(umax(ps_to_clk(T_WP_PS, CLK_PERIOD_PS),
                                                     ps_to_clk(T_CW_PS, CLK_PERIOD_PS)),
                                                umax(ps_to_clk(T_AW_PS, CLK_PERIOD_PS),
                                                     ps_to_clk(T_DW_PS, CLK_PERIOD_PS))));
  localparam int unsigned WC_CYC = ps_to_clk(T_WC_PS, CLK_PERIOD_PS);
  localparam int unsigned RC_CYC = (WC_CYC > WP_CYC + 1) ? (WC_CYC - WP_CYC) : 1;
  localparam int unsigned TA_CYC = umax(1, ps_to_clk(T_HZ_PS, CLK_PERIOD_PS));
  localparam int unsigned MAX_CYC = umax(umax(RD_CYC, WP_CYC), umax(RC_CYC, TA_CYC));
  localparam int unsigned CNT_W  = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic             req_fire;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_last;
  logic             capture;
  logic             finish;
  phase_e           phase_d;

  sram_seq_fsm #(
    .CNT_W(CNT_W), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .RC_CYC(RC_CYC), .TA_CYC(TA_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .timer_last(tmr_last), .req_ready(req_ready), .req_fire(req_fire),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .phase_d(phase_d),
    .capture(capture), .finish(finish)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  sram_pin_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .phase_d(phase_d), .req_fire(req_fire),
    .req_addr(req_addr), .req_wdata(req_wdata), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .capture(capture), .finish(finish),
    .sram_dq_i(sram_dq_i), .done(done), .rd_data(rd_data)
  );

  assert_ready_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !done) |-> sram_ce_n);

  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> !req_ready);

endmodule

// File: tb/async_sram_ctl_bench.sv
`timescale 1ns/1ps
module async_sram_ctl_bench;
  localparam int CLK_NS   = 4;
  localparam int PER_PS   = CLK_NS * 1000;
  localparam int WC_PS    = 20000;

  function automatic int cdiv(input int ps);
    return (ps + PER_PS - 1) / PER_PS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD  = mx(1, mx(mx(cdiv(12000), cdiv(12000)), mx(cdiv(12000), cdiv(6000))));
  localparam int E_WP  = mx(1, mx(mx(cdiv(10000), cdiv(10000)), mx(cdiv(10000), cdiv(6000))));
  localparam int E_REC = mx(1, cdiv(WC_PS) - E_WP);
  localparam int E_TA  = mx(1, cdiv(6000));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, done;
  logic [7:0] rd_data, sram_dq_o;
  logic [14:0] sram_addr;
  logic sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [7:0] sram_dq_i = 8'hEE;

  async_sram_ctl #(.CLK_PERIOD_PS(PER_PS), .T_WC_PS(WC_PS)) u_async_sram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_dq_o(sram_dq_o),
    .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  always #(CLK_NS/2) clk = ~clk;

  typedef struct {
    logic ce_n, oe_n, we_n, dq_oe, ready, done, chk_rd;
    logic [14:0] addr;
    logic [7:0] dq, rd;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  logic [7:0] mem [0:255];
  logic [7:0] ref_mem [0:255];
  logic [7:0] last_rd = 8'h00;
  bit model_last_rd = 0;
  bit running = 0;
  int checks = 0, fails = 0, cycles = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic exp_t mk(input logic ce, input logic oe, input logic we, input logic doe,
                              input logic rdy, input logic dn, input logic [14:0] a,
                              input logic [7:0] d, input string tag);
    exp_t e;
    e.ce_n = ce; e.oe_n = oe; e.we_n = we; e.dq_oe = doe; e.ready = rdy; e.done = dn;
    e.addr = a; e.dq = d; e.chk_rd = 1'b0; e.rd = 8'h00; e.tag = tag;
    return e;
  endfunction

  // Per-cycle reference model and memory model, sampled 1 ns after each rising edge.
  always @(posedge clk) begin
    #1;
    cycles++;
    if (running) begin
      exp_t e;
      bit ok;
      if (exp_q.size() != 0) e = exp_q.pop_front();
      else e = mk(1, 1, 1, 0, 1, 0, '0, '0, "R9");
      ok = (sram_ce_n == e.ce_n) && (sram_oe_n == e.oe_n) && (sram_we_n == e.we_n) &&
           (sram_dq_oe == e.dq_oe) && (req_ready == e.ready) && (done == e.done);
      chk(ok, e.tag, "pins{ce,oe,we,dqoe,rdy,done}",
          {26'd0, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, req_ready, done},
          {26'd0, e.ce_n, e.oe_n, e.we_n, e.dq_oe, e.ready, e.done});
      if (!e.ce_n) chk(sram_addr == e.addr, "R2", "addr", 32'(sram_addr), 32'(e.addr));
      if (e.dq_oe) chk(sram_dq_o == e.dq, "R5", "dq_o", 32'(sram_dq_o), 32'(e.dq));
      if (e.chk_rd) chk(rd_data == e.rd, "R4", "rd_data", 32'(rd_data), 32'(e.rd));
      if (sram_dq_oe) chk(!sram_we_n && sram_oe_n, "R8", "drive while oe_n low",
                          {30'd0, sram_we_n, sram_oe_n}, 32'd1);
    end
    if (!sram_ce_n && !sram_we_n && sram_dq_oe) mem[sram_addr[7:0]] = sram_dq_o;
    sram_dq_i = (!sram_ce_n && !sram_oe_n && sram_we_n) ? mem[sram_addr[7:0]] : 8'hEE;
  end

  task automatic op(input bit wr, input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    while (exp_q.size() != 0) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (!wr) begin
      exp_t e;
      for (int i = 0; i < E_RD; i++) exp_q.push_back(mk(0, 0, 1, 0, 0, 0, a, d, "R3"));
      last_rd = ref_mem[a[7:0]];
      e = mk(1, 1, 1, 0, 1, 1, a, d, "R4");
      e.chk_rd = 1'b1; e.rd = last_rd;
      exp_q.push_back(e);
      model_last_rd = 1;
    end else begin
      exp_t e;
      if (model_last_rd)
        for (int i = 0; i < E_TA; i++) exp_q.push_back(mk(0, 1, 1, 0, 0, 0, a, d, "R7"));
      for (int i = 0; i < E_WP; i++) exp_q.push_back(mk(0, 1, 0, 1, 0, 0, a, d, "R5"));
      for (int i = 0; i < E_REC; i++) exp_q.push_back(mk(0, 1, 1, 0, 0, 0, a, d, "R6"));
      e = mk(1, 1, 1, 0, 1, 1, a, d, "R6");
      e.chk_rd = 1'b1; e.rd = last_rd;
      exp_q.push_back(e);
      ref_mem[a[7:0]] = d;
      model_last_rd = 0;
    end
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      ref_mem[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && req_ready && !done, "R1",
        "reset pins", {26'd0, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, req_ready, done},
        32'h3A);
    rst_n = 1'b1;
    @(negedge clk);
    running = 1;
    op(1, 15'h0000, 8'hA5);
    op(0, 15'h0000, 8'h00);
    op(1, 15'h7FFF, 8'h3C);
    op(0, 15'h7FFF, 8'h00);
    op(0, 15'h0042, 8'h00);
    op(1, 15'h1234, 8'hFF);
    op(1, 15'h2201, 8'h00);
    repeat (3) @(negedge clk);
    op(0, 15'h1234, 8'h00);
    op(0, 15'h2201, 8'h00);
    op(1, 15'h0000, 8'h11);
    op(0, 15'h0000, 8'h00);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", cycles, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule